// File: doc/BRIEF.md
# SPI EEPROM Write Sequencer with Completion Polling

This block sits on the master side of an SPI link to a serial EEPROM and carries out one complete write operation per request. It frames a write-enable command in its own chip-select window. It then opens a second window holding the write opcode, the target address (most significant byte first) and the payload bytes. Once chip select is released, it waits for the memory's internal programming cycle to finish. It does not shift bits itself. It drives a byte-level SPI engine: for each byte it presents the byte, pulses a start strobe, and waits for the engine's done strobe together with the byte received in that slot.

Completion is found in one of two ways, chosen for each request. In polling mode the block repeats read-status transactions and finishes on the first status byte whose busy flag (bit 0) is clear. A per-request poll limit ends a memory that never clears with an error. In fixed-wait mode the block counts a set number of clock cycles, which stands for the worst-case programming time, and sends no status reads. The block also keeps a minimum chip-select high time between any two transactions. After every operation it reports an estimated bus load time.

Payload bytes arrive on a valid/ready stream. `wr_data_ready` is high only while the block is in its data phase and the engine is free. A byte is taken on a clock edge where valid and ready are both high, and it is sent in that same cycle. The producer may hold valid low for as long as it likes. Chip select then stays low and no byte is started. Once valid is raised it must stay high, with the same data, until the byte is taken.

Top module: `eeprom_write_poller`

## Requirements
- R1: During and right after reset, chip select is high (`spi_cs_n`=1), `spi_start` and `op_done` are low, and `req_ready` is high.
- R2: Each accepted write begins with a transaction that carries exactly one byte, the write-enable opcode 0x06, framed by its own chip-select low window.
- R3: The next transaction holds opcode 0x02, then ADDR_BYTES address bytes most significant first, then exactly `req_len` payload bytes in stream order, all inside one chip-select low window.
- R4: In polling mode (`req_fixed_wait`=0), each poll is a two-byte transaction 0x05 then 0x00. Bit 0 of the byte received in the second slot is the busy flag. Polling repeats while it is 1, and the first 0 ends the operation with a one-cycle `op_done` and `op_error`=0.
- R5: In fixed-wait mode no status transaction is issued, and `op_done` rises exactly WAIT_CYC+1 cycles after chip select rises at the end of the write transaction.
- R6: When `req_poll_limit` is nonzero and that many polls in a row return busy=1, the operation ends with `op_done` and `op_error`=1 after exactly that many polls. A limit of 0 means no limit.
- R7: Chip select stays high for at least CS_GAP cycles before every falling edge.
- R8: After an accepted write completes, `load_time_ns` equals 8·(2+ADDR_BYTES+`req_len`)·SCK_PERIOD_NS + SEL_OVH_NS.
- R9: `wr_data_ready` is high only with chip select low. While it is high, `spi_start` equals `wr_data_valid`, so a stalled stream holds the transfer.
- R10: A request with `req_len`=0, or one whose address offset inside its PAGE_BYTES page plus `req_len` exceeds PAGE_BYTES, produces no SPI transaction and ends with `op_done` and `op_error`=1.
- R11: `req_ready` is high exactly when no operation is in progress. It drops the cycle after a request is accepted and returns the cycle after `op_done`.
- R12: `spi_start` pulses for one cycle, only while chip select is low, and never twice without a done in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_addr | input | 8·ADDR_BYTES | Start address of the write |
| req_len | input | clog2(PAGE_BYTES+1) | Number of payload bytes |
| req_fixed_wait | input | 1 | 1: fixed cycle wait, 0: status polling |
| req_poll_limit | input | POLL_W | Busy polls before error, 0 = unlimited |
| wr_data_valid | input | 1 | Payload byte present |
| wr_data_ready | output | 1 | Payload byte taken this cycle when valid |
| wr_data | input | 8 | Payload byte |
| spi_cs_n | output | 1 | Chip select to the memory, active low |
| spi_tx_byte | output | 8 | Byte for the engine to shift out |
| spi_start | output | 1 | Start one byte transfer |
| spi_done | input | 1 | Engine finished the byte in flight |
| spi_rx_byte | input | 8 | Byte received in that slot, valid with `spi_done` |
| op_done | output | 1 | One-cycle end-of-operation pulse |
| op_error | output | 1 | Qualifies `op_done`: timeout or rejected request |
| load_time_ns | output | 32 | Bus load time estimate of the last operation |

## Verification
The assertions assume the engine raises `spi_done` only for a byte it was started on. They also assume `wr_data_valid`, once raised, is not withdrawn before it is taken. The bench's engine model answers each start with a single done four cycles later. Its stream driver keeps valid and data steady until a handshake, and it may insert idle cycles with valid low. Requests are presented only when the model expects the block to be idle. Their address and length are chosen on both sides of the page-fit rule.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WREN,
    S_WREN_END,
    S_CMD,
    S_ADDR,
    S_DATA,
    S_WR_END,
    S_POLL_CMD,
    S_POLL_RD,
    S_POLL_END,
    S_DELAY,
    S_FINISH
  } wp_state_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_DUMMY = 8'h00;
  localparam logic [7:0] WIP_MASK = 8'h01;

endpackage

// File: rtl/wp_cs_gap.sv
module wp_cs_gap #(
  parameter int CS_GAP = 4,
  localparam int CW = $clog2(CS_GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic gap_ok
);

  logic [CW-1:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_cnt <= CW'(CS_GAP);
    end else if (!cs_n) begin
      high_cnt <= '0;
    end else if (high_cnt != CW'(CS_GAP)) begin
      high_cnt <= high_cnt + 1'b1;
    end
  end

  assign gap_ok = cs_n && (high_cnt == CW'(CS_GAP));

  // R7: select may only fall after the full high interval has elapsed
  p_gap_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(high_cnt) == CW'(CS_GAP));

endmodule

// File: rtl/wp_wait_timer.sv
module wp_wait_timer #(
  parameter int WAIT_CYC = 625000,
  localparam int TW = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  logic [TW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (load) begin
      left <= TW'(WAIT_CYC);
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign expired = (left == '0);

  // R5: a fresh load always starts a non-expired interval
  p_load_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired);

endmodule

// File: rtl/wp_load_meter.sv
module wp_load_meter #(
  parameter int ADDR_BYTES    = 2,
  parameter int PAGE_BYTES    = 64,
  parameter int SCK_PERIOD_NS = 1000,
  parameter int SEL_OVH_NS    = 150,
  localparam int BW = $clog2(PAGE_BYTES + ADDR_BYTES + 3)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        byte_tick,
  output logic [31:0] load_time_ns
);

  logic [BW-1:0] nbytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbytes <= '0;
    end else if (clear) begin
      nbytes <= '0;
    end else if (byte_tick) begin
      nbytes <= nbytes + 1'b1;
    end
  end

  assign load_time_ns = 32'(nbytes) * 32'(8 * SCK_PERIOD_NS) + 32'(SEL_OVH_NS);

  // R8: each counted byte adds one byte time to the estimate
  p_tick_adds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_tick && !clear) |=> load_time_ns == $past(load_time_ns) + 32'(8 * SCK_PERIOD_NS));

endmodule

// File: rtl/eeprom_write_poller.sv
module eeprom_write_poller
  import wp_pkg::*;
#(
  parameter int ADDR_BYTES    = 2,
  parameter int PAGE_BYTES    = 64,
  parameter int CS_GAP        = 4,
  parameter int WAIT_CYC      = 625000,
  parameter int POLL_W        = 16,
  parameter int SCK_PERIOD_NS = 1000,
  parameter int SEL_OVH_NS    = 150,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int LEN_W  = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_fixed_wait,
  input  logic [POLL_W-1:0] req_poll_limit,
  input  logic              wr_data_valid,
  output logic              wr_data_ready,
  input  logic [7:0]        wr_data,
  output logic              spi_cs_n,
  output logic [7:0]        spi_tx_byte,
  output logic              spi_start,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx_byte,
  output logic              op_done,
  output logic              op_error,
  output logic [31:0]       load_time_ns
);

  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int IDX_W = $clog2(ADDR_BYTES + 1);
  localparam int SPAN_W = LEN_W + 1;

  wp_state_e         state;
  logic              cs_n_q;
  logic              inflight;
  logic [ADDR_W-1:0] addr_sh;
  logic [IDX_W-1:0]  addr_idx;
  logic [LEN_W-1:0]  rem;
  logic              fixed_q;
  logic [POLL_W-1:0] limit_q;
  logic [POLL_W-1:0] polls;
  logic              wip_clear;
  logic              err_q;

  logic              gap_ok;
  logic              wait_expired;
  logic              wait_load;
  logic              send_st;
  logic              load_st;
  logic              byte_fin;
  logic              req_bad;
  logic [SPAN_W-1:0] span;

  // ---------------------------------------------------------------
  // helpers
  // ---------------------------------------------------------------
  wp_cs_gap #(.CS_GAP(CS_GAP)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n_q),
    .gap_ok (gap_ok)
  );

  wp_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wait_load),
    .expired (wait_expired)
  );

  wp_load_meter #(
    .ADDR_BYTES    (ADDR_BYTES),
    .PAGE_BYTES    (PAGE_BYTES),
    .SCK_PERIOD_NS (SCK_PERIOD_NS),
    .SEL_OVH_NS    (SEL_OVH_NS)
  ) u_meter (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (req_valid && req_ready),
    .byte_tick    (spi_start && load_st),
    .load_time_ns (load_time_ns)
  );

  // ---------------------------------------------------------------
  // combinational decode
  // ---------------------------------------------------------------
  assign span    = SPAN_W'(req_addr[OFS_W-1:0]) + SPAN_W'(req_len);
  assign req_bad = (req_len == '0) || (span > SPAN_W'(PAGE_BYTES));

  assign send_st = (state == S_WREN) || (state == S_CMD) || (state == S_ADDR) ||
                   (state == S_DATA) || (state == S_POLL_CMD) || (state == S_POLL_RD);
  assign load_st = (state == S_WREN) || (state == S_CMD) || (state == S_ADDR) ||
                   (state == S_DATA);

  assign spi_start     = send_st && !cs_n_q && !inflight &&
                         ((state != S_DATA) || wr_data_valid);
  assign wr_data_ready = (state == S_DATA) && !cs_n_q && !inflight;
  assign byte_fin      = spi_done && inflight;
  assign wait_load     = (state == S_WR_END) && fixed_q;

  always_comb begin
    unique case (state)
      S_WREN:     spi_tx_byte = OP_WREN;
      S_CMD:      spi_tx_byte = OP_WRITE;
      S_ADDR:     spi_tx_byte = addr_sh[ADDR_W-1 -: 8];
      S_DATA:     spi_tx_byte = wr_data;
      S_POLL_CMD: spi_tx_byte = OP_RDSR;
      default:    spi_tx_byte = OP_DUMMY;
    endcase
  end

  assign spi_cs_n  = cs_n_q;
  assign req_ready = (state == S_IDLE);
  assign op_done   = (state == S_FINISH);
  assign op_error  = (state == S_FINISH) && err_q;

  // ---------------------------------------------------------------
  // sequencer
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cs_n_q    <= 1'b1;
      inflight  <= 1'b0;
      addr_sh   <= '0;
      addr_idx  <= '0;
      rem       <= '0;
      fixed_q   <= 1'b0;
      limit_q   <= '0;
      polls     <= '0;
      wip_clear <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (spi_start) begin
        inflight <= 1'b1;
      end else if (byte_fin) begin
        inflight <= 1'b0;
      end

      if (send_st && cs_n_q && gap_ok) begin
        cs_n_q <= 1'b0;
      end

      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            addr_sh   <= req_addr;
            rem       <= req_len;
            fixed_q   <= req_fixed_wait;
            limit_q   <= req_poll_limit;
            polls     <= '0;
            wip_clear <= 1'b0;
            err_q     <= req_bad;
            state     <= req_bad ? S_FINISH : S_WREN;
          end
        end
        S_WREN: begin
          if (byte_fin) state <= S_WREN_END;
        end
        S_WREN_END: begin
          cs_n_q <= 1'b1;
          state  <= S_CMD;
        end
        S_CMD: begin
          if (byte_fin) begin
            addr_idx <= '0;
            state    <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (byte_fin) begin
            addr_sh  <= addr_sh << 8;
            addr_idx <= addr_idx + 1'b1;
            if (addr_idx == IDX_W'(ADDR_BYTES - 1)) state <= S_DATA;
          end
        end
        S_DATA: begin
          if (byte_fin) begin
            rem <= rem - 1'b1;
            if (rem == LEN_W'(1)) state <= S_WR_END;
          end
        end
        S_WR_END: begin
          cs_n_q <= 1'b1;
          state  <= fixed_q ? S_DELAY : S_POLL_CMD;
        end
        S_POLL_CMD: begin
          if (byte_fin) state <= S_POLL_RD;
        end
        S_POLL_RD: begin
          if (byte_fin) begin
            wip_clear <= ((spi_rx_byte & WIP_MASK) == 8'h00);
            state     <= S_POLL_END;
          end
        end
        S_POLL_END: begin
          cs_n_q <= 1'b1;
          if (wip_clear) begin
            state <= S_FINISH;
          end else if ((limit_q != '0) && ((polls + 1'b1) == limit_q)) begin
            err_q <= 1'b1;
            state <= S_FINISH;
          end else begin
            polls <= polls + 1'b1;
            state <= S_POLL_CMD;
          end
        end
        S_DELAY: begin
          if (wait_expired) state <= S_FINISH;
        end
        S_FINISH: begin
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------------------------------------------------------
  // assertions
  // ---------------------------------------------------------------
  p_idle_cs_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n);

  p_start_cs_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !spi_cs_n);

  p_start_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |=> !spi_start);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_ready_cs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_ready |-> !spi_cs_n);

  p_fixed_no_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_q && !req_ready) |-> (state != S_POLL_RD));

endmodule

// File: tb/sim_eeprom_write_poller.sv
module sim_eeprom_write_poller;

  localparam int AB = 2;
  localparam int PG = 16;
  localparam int GAP = 3;
  localparam int WC = 40;
  localparam int PW = 8;
  localparam int SCK = 1000;
  localparam int OVH = 150;
  localparam int LW = $clog2(PG + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [8*AB-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic req_fixed_wait = 1'b0;
  logic [PW-1:0] req_poll_limit = '0;
  logic wr_data_valid = 1'b0;
  logic wr_data_ready;
  logic [7:0] wr_data = 8'h00;
  logic spi_cs_n;
  logic [7:0] spi_tx_byte;
  logic spi_start;
  logic spi_done = 1'b0;
  logic [7:0] spi_rx_byte = 8'h00;
  logic op_done;
  logic op_error;
  logic [31:0] load_time_ns;

  always #4 clk = ~clk;

  eeprom_write_poller #(
    .ADDR_BYTES(AB), .PAGE_BYTES(PG), .CS_GAP(GAP), .WAIT_CYC(WC),
    .POLL_W(PW), .SCK_PERIOD_NS(SCK), .SEL_OVH_NS(OVH)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_fixed_wait(req_fixed_wait),
    .req_poll_limit(req_poll_limit), .wr_data_valid(wr_data_valid),
    .wr_data_ready(wr_data_ready), .wr_data(wr_data), .spi_cs_n(spi_cs_n),
    .spi_tx_byte(spi_tx_byte), .spi_start(spi_start), .spi_done(spi_done),
    .spi_rx_byte(spi_rx_byte), .op_done(op_done), .op_error(op_error),
    .load_time_ns(load_time_ns)
  );

  int ncheck = 0;
  int nbad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    ncheck++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model state
  byte unsigned log_b[$];
  int           txn_len[$];
  byte unsigned dq[$];
  int  cyc = 0;
  int  eng_cnt = 0;
  byte unsigned eng_rx = 0;
  bit  hs_seen = 0;
  bit  stall_mode = 0;
  bit  pending = 0;
  bit  prev_cs = 1;
  int  high_run = 0;
  int  rise_cyc = 0;
  int  done_cyc = 0;
  bit  done_seen = 0;
  bit  done_err = 0;
  int  busy_n = 0;
  int  rdsr_cnt = 0;
  byte unsigned cur_first = 0;

  // per-clock engine, stream driver and monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      spi_done = 1'b0;
      if (eng_cnt > 0) begin
        eng_cnt--;
        if (eng_cnt == 0) begin
          spi_done = 1'b1;
          spi_rx_byte = eng_rx;
        end
      end
      if (hs_seen) begin
        void'(dq.pop_front());
        wr_data_valid = 1'b0;
      end
      if (!wr_data_valid && dq.size() > 0 && !(stall_mode && (cyc % 5 != 0))) begin
        wr_data_valid = 1'b1;
        wr_data = dq[0];
      end
      #1;
      hs_seen = wr_data_valid && wr_data_ready;
      if (rst_n) begin
        chk(req_ready == !pending, "R11", req_ready, !pending);
        if (spi_start) chk(!spi_cs_n, "R12", spi_cs_n, 0);
        if (spi_start && eng_cnt != 0) chk(0, "R12", eng_cnt, 0);
        if (wr_data_ready) chk(!spi_cs_n && (spi_start == wr_data_valid), "R9", spi_start, wr_data_valid);
        if (prev_cs && !spi_cs_n) begin
          chk(high_run >= GAP, "R7", high_run, GAP);
          txn_len.push_back(0);
        end
        if (!prev_cs && spi_cs_n) rise_cyc = cyc;
        if (spi_start) begin
          if (txn_len.size() == 0) txn_len.push_back(0);
          if (txn_len[txn_len.size()-1] == 0) cur_first = spi_tx_byte;
          eng_rx = 8'hFF;
          if (txn_len[txn_len.size()-1] == 1 && cur_first == 8'h05) begin
            eng_rx = (rdsr_cnt < busy_n) ? 8'h03 : 8'h02;
            rdsr_cnt++;
          end
          log_b.push_back(spi_tx_byte);
          txn_len[txn_len.size()-1] += 1;
          eng_cnt = 4;
        end
        if (op_done) begin
          done_seen = 1;
          done_err = op_error;
          done_cyc = cyc;
          pending = 0;
        end
        if (req_valid && req_ready) pending = 1;
      end
      high_run = spi_cs_n ? high_run + 1 : 0;
      prev_cs = spi_cs_n;
    end
  end

  task automatic run_op(input int addr, input int len, input bit fixed, input int limit,
                        input int nbusy, input bit stall, input bit expect_reject);
    byte unsigned exp_b[$];
    int exp_len[$];
    int n_rdsr;
    int nb;
    log_b.delete();
    txn_len.delete();
    busy_n = nbusy;
    rdsr_cnt = 0;
    stall_mode = stall;
    done_seen = 0;
    if (!expect_reject) begin
      exp_b.push_back(8'h06);
      exp_len.push_back(1);
      exp_b.push_back(8'h02);
      exp_b.push_back(8'((addr >> 8) & 8'hFF));
      exp_b.push_back(8'(addr & 8'hFF));
      for (int i = 0; i < len; i++) begin
        byte unsigned d;
        d = 8'((addr + 37 * i + 11) & 8'hFF);
        dq.push_back(d);
        exp_b.push_back(d);
      end
      exp_len.push_back(3 + len);
      if (fixed) n_rdsr = 0;
      else if (limit != 0 && nbusy >= limit) n_rdsr = limit;
      else n_rdsr = nbusy + 1;
      for (int i = 0; i < n_rdsr; i++) begin
        exp_b.push_back(8'h05);
        exp_b.push_back(8'h00);
        exp_len.push_back(2);
      end
    end
    @(negedge clk);
    req_addr = 16'(addr);
    req_len = LW'(len);
    req_fixed_wait = fixed;
    req_poll_limit = PW'(limit);
    req_valid = 1'b1;
    #2;
    while (!req_ready) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 20000 && !done_seen; t++) @(negedge clk);
    #2;
    chk(done_seen, "R4", done_seen, 1);
    chk(txn_len.size() == exp_len.size(), expect_reject ? "R10" : "R2", txn_len.size(), exp_len.size());
    nb = (log_b.size() < exp_b.size()) ? log_b.size() : exp_b.size();
    chk(log_b.size() == exp_b.size(), "R3", log_b.size(), exp_b.size());
    for (int i = 0; i < nb; i++) begin
      if (log_b[i] != exp_b[i])
        chk(0, (i == 0) ? "R2" : ((i < 4 + len) ? "R3" : "R4"), log_b[i], exp_b[i]);
    end
    for (int i = 0; i < txn_len.size() && i < exp_len.size(); i++)
      if (txn_len[i] != exp_len[i]) chk(0, "R3", txn_len[i], exp_len[i]);
    if (expect_reject) chk(done_err == 1, "R10", done_err, 1);
    else if (!fixed && limit != 0 && nbusy >= limit) chk(done_err == 1, "R6", done_err, 1);
    else chk(done_err == 0, "R4", done_err, 0);
    if (!expect_reject) chk(load_time_ns == 32'(8 * (2 + AB + len) * SCK + OVH), "R8",
                            load_time_ns, 8 * (2 + AB + len) * SCK + OVH);
    if (fixed) chk(done_cyc - rise_cyc == WC + 1, "R5", done_cyc - rise_cyc, WC + 1);
    dq.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #1;
    chk(spi_cs_n == 1'b1, "R1", spi_cs_n, 1);
    chk(spi_start == 1'b0, "R1", spi_start, 0);
    chk(op_done == 1'b0, "R1", op_done, 0);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(spi_cs_n == 1'b1 && req_ready == 1'b1, "R1", spi_cs_n, 1);
    // polling, two busy reads then clear
    run_op(16'h0123, 4, 0, 0, 2, 0, 0);
    // full page at boundary, stalled stream
    run_op(16'h00F0, 16, 0, 0, 0, 1, 0);
    // fixed wait
    run_op(16'h0A05, 1, 1, 0, 5, 0, 0);
    // timeout after three busy polls
    run_op(16'h0040, 2, 0, 3, 100, 0, 0);
    // rejected: zero length, page crossing
    run_op(16'h0200, 0, 0, 0, 0, 0, 1);
    run_op(16'h001E, 3, 0, 0, 0, 0, 1);
    // clears on the last allowed poll
    run_op(16'h0311, 5, 0, 5, 4, 1, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", ncheck, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      ncheck++;
      nbad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("  test done: total=%0d bad=%0d", ncheck, nbad);
      $finish;
    end
  end

endmodule